// File: doc/BRIEF.md
# I2C Multi-Master Lockup Recovery Controller

This block watches an I2C master interface that shares its bus with other masters. It recovers the interface when a collision leaves it locked. Each transfer start arms a timeout counter. If the interface's completion interrupt arrives in time, the block reports success and goes back to waiting. If the counter runs out first, the block holds a reset on the serial interface for a fixed number of cycles. A master device then waits a backoff of ten cycles per unit of its device ID, so that masters which collided restart at different times. After the backoff it looks at the bus-idle status once. If the bus is free it requests a resend. If the bus is busy it concludes that another master won the bus and reports a yield. A configuration input can skip the backoff. A device that is not acting as master only resets the interface and returns to idle. A retry limiter counts recoveries in a row. When the limit is reached it raises a sticky error and stops requesting resends.

The state machine has these states:
- IDLE: waits for a start.
- WAIT: timeout running.
- SUCCESS: one-cycle success pulse.
- RESET: interface reset held.
- BACKOFF: ID-scaled delay.
- CHECK: bus-idle sample.
- RETRY: one-cycle resend request.
- YIELD: one-cycle yield pulse.

The transitions are:
- IDLE to WAIT on start.
- WAIT to SUCCESS on the interrupt.
- WAIT to RESET on expiry.
- SUCCESS to IDLE.
- RESET to IDLE when the device is not a master or the limit is reached.
- RESET to CHECK when the backoff is bypassed.
- RESET to BACKOFF otherwise.
- BACKOFF to CHECK on expiry.
- CHECK to RETRY when the bus is idle.
- CHECK to YIELD when the bus is busy.
- RETRY to IDLE and YIELD to IDLE.

Top module: `i2c_lockup_recovery`

## Requirements
- R1: After reset, `sif_reset`, `retry_req`, `yield`, `success` and `err_sticky` are all 0 and the block is idle.
- R2: The rising edge that samples `xfer_start` high in idle is edge 0, and the timeout period T is `timeout_cycles`, with 0 treated as 1. If `done_irq` is sampled high at any edge 1..T, `success` is high for exactly one cycle after that edge and `sif_reset` never rises.
- R3: With no `done_irq` at edges 1..T, `sif_reset` goes high in the cycle after edge T.
- R4: `sif_reset` stays high for exactly RST_CYCLES cycles, where values below 2 are raised to 2.
- R5: If `is_master` is 0 when the reset ends, the block returns to idle and neither `retry_req` nor `yield` is pulsed.
- R6: For a master with `backoff_bypass`=0, the backoff lasts B = `dev_id`*10 cycles, or 1 cycle when `dev_id` is 0. One bus-check cycle follows. `retry_req` is then high for one cycle, first seen T+RST_CYCLES+B+1 cycles after edge 0, when `bus_idle` is 1 at the check.
- R7: If `bus_idle` is 0 at the check, `yield` is pulsed for one cycle in place of `retry_req`.
- R8: With `backoff_bypass`=1, B is 0 and the result appears T+RST_CYCLES+1 cycles after edge 0.
- R9: Each timeout counts one recovery. A `success` or a `yield` clears the count. The timeout that brings the count to MAX_RETRY sets `err_sticky` and returns to idle without a check. `err_sticky` stays set until `err_clear`, which also clears the count.
- R10: `done_irq` outside WAIT, and `xfer_start` outside IDLE, are ignored. No `success` results from them, and recovery timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Transfer start strobe |
| done_irq | input | 1 | Completion interrupt from the serial interface |
| bus_idle | input | 1 | Bus free status |
| dev_id | input | ID_W | Device ID scaling the backoff |
| is_master | input | 1 | Device is acting as master |
| backoff_bypass | input | 1 | Skip the backoff delay |
| timeout_cycles | input | TO_W | Timeout period in cycles |
| err_clear | input | 1 | Clears the sticky error and the recovery count |
| sif_reset | output | 1 | Reset to the serial interface |
| retry_req | output | 1 | One-cycle resend request |
| yield | output | 1 | One-cycle report that another master owns the bus |
| success | output | 1 | One-cycle transfer completed |
| err_sticky | output | 1 | Retry limit reached |

## Verification
Each state drives at most one output, so a wrong state or a miscounting counter shows at the ports as a shifted or missing pulse. A timeout counter that is off by one moves the `sif_reset` rise by a cycle, right at edge T. A bad backoff load moves `retry_req` or `yield` by multiples of ten cycles. An inverted bus check swaps those two pulses in the cycle after the check. A lost recovery count shows as a resend where `err_sticky` should have risen, on the third timeout in a row.

// File: rtl/lkr_pkg.sv
package lkr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_SUCCESS,
        S_RESET,
        S_BACKOFF,
        S_CHECK,
        S_RETRY,
        S_YIELD
    } lkr_state_e;
endpackage

// File: rtl/lkr_downcnt.sv
module lkr_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

    // R6
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/lkr_retry_limit.sv
module lkr_retry_limit #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    input  logic clr_ok,
    input  logic err_clear,
    output logic limit_hit,
    output logic err_sticky
);
    localparam int MAX_EFF = (MAX_RETRY < 1) ? 1 : MAX_RETRY;
    localparam int CW      = $clog2(MAX_EFF + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            err_sticky <= 1'b0;
        end else if (err_clear) begin
            count      <= '0;
            err_sticky <= 1'b0;
        end else if (bump) begin
            if (count != CW'(MAX_EFF))
                count <= count + CW'(1);
            if (count == CW'(MAX_EFF - 1))
                err_sticky <= 1'b1;
        end else if (clr_ok) begin
            count <= '0;
        end
    end

    assign limit_hit = (count == CW'(MAX_EFF));

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> $past(bump));

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_EFF));
endmodule

// File: rtl/i2c_lockup_recovery.sv
module i2c_lockup_recovery
    import lkr_pkg::*;
#(
    parameter int TO_W       = 16,
    parameter int ID_W       = 7,
    parameter int RST_CYCLES = 4,
    parameter int MAX_RETRY  = 3,
    parameter int BO_MULT    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_start,
    input  logic            done_irq,
    input  logic            bus_idle,
    input  logic [ID_W-1:0] dev_id,
    input  logic            is_master,
    input  logic            backoff_bypass,
    input  logic [TO_W-1:0] timeout_cycles,
    input  logic            err_clear,
    output logic            sif_reset,
    output logic            retry_req,
    output logic            yield,
    output logic            success,
    output logic            err_sticky
);
    localparam int RST_EFF = (RST_CYCLES < 2) ? 2 : RST_CYCLES;
    localparam int RC_W    = $clog2(RST_EFF + 1);
    localparam int BO_MAX  = ((1 << ID_W) - 1) * BO_MULT;
    localparam int BO_W    = $clog2(BO_MAX + 1);

    lkr_state_e state, state_nx;

    logic [TO_W-1:0] to_cnt, to_val;
    logic [RC_W-1:0] rs_cnt;
    logic [BO_W-1:0] bo_cnt, bo_val, bo_prod;
    logic            to_last, rs_last, bo_last;
    logic            load_to, load_rs, load_bo;
    logic            limit_hit;

    assign to_val  = (timeout_cycles == '0) ? TO_W'(1) : timeout_cycles;
    assign bo_prod = BO_W'(dev_id) * BO_W'(BO_MULT);
    assign bo_val  = (bo_prod == '0) ? BO_W'(1) : bo_prod;

    assign load_to = (state == S_IDLE) && xfer_start;
    assign load_rs = (state == S_WAIT) && !done_irq && to_last;
    assign load_bo = (state == S_RESET) && rs_last;

    lkr_downcnt #(.W(TO_W)) u_timeout (
        .clk(clk), .rst_n(rst_n), .load(load_to), .load_val(to_val),
        .dec(state == S_WAIT), .cnt(to_cnt), .last(to_last)
    );

    lkr_downcnt #(.W(RC_W)) u_rst_width (
        .clk(clk), .rst_n(rst_n), .load(load_rs), .load_val(RC_W'(RST_EFF)),
        .dec(state == S_RESET), .cnt(rs_cnt), .last(rs_last)
    );

    lkr_downcnt #(.W(BO_W)) u_backoff (
        .clk(clk), .rst_n(rst_n), .load(load_bo), .load_val(bo_val),
        .dec(state == S_BACKOFF), .cnt(bo_cnt), .last(bo_last)
    );

    lkr_retry_limit #(.MAX_RETRY(MAX_RETRY)) u_limit (
        .clk(clk), .rst_n(rst_n), .bump(load_rs),
        .clr_ok(state == S_SUCCESS || state == S_YIELD),
        .err_clear(err_clear), .limit_hit(limit_hit), .err_sticky(err_sticky)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (xfer_start) state_nx = S_WAIT;
            S_WAIT: begin
                if (done_irq)     state_nx = S_SUCCESS;
                else if (to_last) state_nx = S_RESET;
            end
            S_SUCCESS: state_nx = S_IDLE;
            S_RESET: begin
                if (rs_last) begin
                    if (!is_master || limit_hit) state_nx = S_IDLE;
                    else if (backoff_bypass)     state_nx = S_CHECK;
                    else                         state_nx = S_BACKOFF;
                end
            end
            S_BACKOFF: if (bo_last) state_nx = S_CHECK;
            S_CHECK:   state_nx = bus_idle ? S_RETRY : S_YIELD;
            S_RETRY:   state_nx = S_IDLE;
            S_YIELD:   state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sif_reset = (state == S_RESET);
        retry_req = (state == S_RETRY);
        yield     = (state == S_YIELD);
        success   = (state == S_SUCCESS);
    end

    // R4
    rst_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sif_reset) |-> $past(sif_reset, 2));

    // R7
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_req, yield, success, sif_reset}));

    // R6
    retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> $past(bus_idle));

    // R7
    yield_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yield |-> !$past(bus_idle));

    // R2
    success_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> $past(done_irq));

    // R10
    retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);
endmodule

// File: tb/tb_i2c_lockup_recovery.sv
module tb_i2c_lockup_recovery;
    localparam int TO_W = 16;
    localparam int ID_W = 7;
    localparam int RSTC = 4;
    localparam int T_DEF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 1'b0, done_irq = 1'b0, bus_idle = 1'b1;
    logic [ID_W-1:0] dev_id = '0;
    logic is_master = 1'b1, backoff_bypass = 1'b0, err_clear = 1'b0;
    logic [TO_W-1:0] timeout_cycles = TO_W'(T_DEF);
    logic sif_reset, retry_req, yield, success, err_sticky;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_lockup_recovery #(.TO_W(TO_W), .ID_W(ID_W), .RST_CYCLES(RSTC), .MAX_RETRY(3)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .done_irq(done_irq),
        .bus_idle(bus_idle), .dev_id(dev_id), .is_master(is_master),
        .backoff_bypass(backoff_bypass), .timeout_cycles(timeout_cycles),
        .err_clear(err_clear), .sif_reset(sif_reset), .retry_req(retry_req),
        .yield(yield), .success(success), .err_sticky(err_sticky)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset_check();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sif_reset, retry_req, yield, success, err_sticky} == 5'b0, "R1", "outputs after reset",
            int'({sif_reset, retry_req, yield, success, err_sticky}), 0);
    endtask

    task automatic do_ok(input int k);
        int rst_seen = 0;
        timeout_cycles = TO_W'(T_DEF);
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        for (int j = 1; j < k; j++) begin
            @(negedge clk);
            if (sif_reset || success) rst_seen++;
        end
        done_irq = 1'b1;
        @(negedge clk);
        done_irq = 1'b0;
        chk(success == 1'b1, "R2", $sformatf("success after done at edge %0d", k), int'(success), 1);
        chk(rst_seen == 0, "R2", "no early reset or success", rst_seen, 0);
        @(negedge clk);
        chk(success == 1'b0, "R2", "success lasts one cycle", int'(success), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_idle_done();
        int seen = 0;
        @(negedge clk);
        done_irq = 1'b1;
        @(negedge clk);
        done_irq = 1'b0;
        for (int j = 0; j < 4; j++) begin
            if (success || sif_reset) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R10", "done_irq in idle ignored", seen, 0);
    endtask

    // kind: 0 none, 1 retry, 2 yield
    task automatic run_timeout(input string tag, input int t, input int id, input bit master,
                               input bit bypass, input bit idle, input bit noise, input int exp_kind);
        int teff, b, lim, exp_idx;
        int first_rst = -1;
        int rw = 0;
        int kind = 0;
        int idx = -1;
        int bad = 0;
        teff = (t == 0) ? 1 : t;
        b = bypass ? 0 : ((id == 0) ? 1 : id * 10);
        exp_idx = teff + RSTC + b + 1;
        lim = exp_idx + 20;
        timeout_cycles = TO_W'(t);
        dev_id = ID_W'(id);
        is_master = master;
        backoff_bypass = bypass;
        bus_idle = idle;
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = noise;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (sif_reset) begin
                if (first_rst < 0) first_rst = i;
                rw++;
            end
            if (success) bad++;
            if (retry_req || yield) begin
                kind = retry_req ? 1 : 2;
                idx = i;
                xfer_start = 1'b0;
                break;
            end
        end
        xfer_start = 1'b0;
        chk(first_rst == teff, "R3", {tag, " reset start"}, first_rst, teff);
        chk(rw == RSTC, "R4", {tag, " reset width"}, rw, RSTC);
        chk(bad == 0, "R10", {tag, " no spurious success"}, bad, 0);
        chk(kind == exp_kind, tag, "result kind", kind, exp_kind);
        if (exp_kind != 0)
            chk(idx == exp_idx, tag, "result cycle", idx, exp_idx);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset_check();
        do_ok(1);
        do_ok(T_DEF);
        do_idle_done();
        run_timeout("R6", T_DEF, 1, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        do_ok(5);
        run_timeout("R6", T_DEF, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        run_timeout("R7", T_DEF, 3, 1'b1, 1'b0, 1'b0, 1'b0, 2);
        run_timeout("R8", 0, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1);
        run_timeout("R5", T_DEF, 2, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        do_ok(3);
        run_timeout("R10", T_DEF, 2, 1'b1, 1'b0, 1'b1, 1'b1, 1);
        do_ok(2);
        // R9: limit of three consecutive recoveries
        run_timeout("R9", 7, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
        chk(err_sticky == 1'b0, "R9", "no error after first", int'(err_sticky), 0);
        run_timeout("R9", 7, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
        chk(err_sticky == 1'b0, "R9", "no error after second", int'(err_sticky), 0);
        run_timeout("R9", 7, 1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
        chk(err_sticky == 1'b1, "R9", "error after third", int'(err_sticky), 1);
        do_ok(2);
        chk(err_sticky == 1'b1, "R9", "error sticky across success", int'(err_sticky), 1);
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk(err_sticky == 1'b0, "R9", "error cleared", int'(err_sticky), 0);
        run_timeout("R9", 7, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1);
        chk(err_sticky == 1'b0, "R9", "count restarted", int'(err_sticky), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule